// File: doc/BRIEF.md
# DMA Channel Address Unit (Memory / Fixed I/O Page)

This block holds the two addresses used by one DMA channel that moves data between memory and a fixed I/O page. The first is a memory-side address register, which the CPU sees as four byte lanes. The second is an 8-bit I/O offset register that selects a location inside an all-ones I/O page. The block has no direction bit. The activation source code alone decides which of the two addresses the transfer reads from and which it writes to. The block drives both addresses as 24-bit bus addresses, one for the read phase and one for the write phase.

Each time the write phase of a byte or word transfer finishes, the memory-side address steps up or down by the transfer size, so a run of transfers walks through memory. The I/O offset stays fixed. Neither register is cleared by reset. Software loads both before it starts the channel. Bus arbitration, the transfer count and interrupts belong to other blocks.

Top module: `dma_addr_unit`

## Requirements
- R1: Memory-register lane 0 is reserved. CPU writes to lane 0 are ignored, and a read of lane 0 returns 0xFF at all times, including straight after reset.
- R2: A CPU write with `cpu_sel_io`=0 stores the byte into the memory register. Lane 1 holds bits 23:16, lane 2 holds bits 15:8 and lane 3 holds bits 7:0, and each lane reads back what was written. With `cpu_sel_io`=1 the write goes to the I/O offset register, and that register reads back whatever the lane value is.
- R3: When `act_src` is 0 (serial receive full) or 1 (conversion end), `rd_addr` is 0xFFFF followed by the I/O offset, `wr_addr` is the low 24 bits of the memory register, and `mem_is_dst` is 1.
- R4: For any other `act_src` code, `rd_addr` is the memory address, `wr_addr` is 0xFFFF followed by the I/O offset, and `mem_is_dst` is 0.
- R5: When `wr_done` is high at a clock edge with `xfer_word`=0 and `xfer_down`=0, the memory address is one higher from the next cycle on.
- R6: When `xfer_word`=1 the step is 2 instead of 1. When `xfer_down`=1 the address is stepped down instead of up.
- R7: Stepping wraps modulo 2^24, so 0xFFFFFF+1 gives 0x000000 and 0x000001-2 gives 0xFFFFFF. Lane 0 still reads 0xFF after a wrap.
- R8: A CPU write to memory lane 1, 2 or 3 in the same cycle as `wr_done` wins. The written byte is stored and no step is applied. A write to reserved lane 0 does not block the step.
- R9: While `wr_done` is low and the CPU does not write, the memory address holds its value.
- R10: Stepping never changes the I/O offset. A CPU write to the I/O offset in a `wr_done` cycle updates the offset, and the memory step still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It only qualifies checking, because the address registers are not reset |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_sel_io | input | 1 | 1 selects the I/O offset register, 0 selects the memory register |
| cpu_lane | input | 2 | Memory register byte lane, where 0 is the most significant |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte for the selected register and lane |
| act_src | input | 3 | Activation source code |
| xfer_word | input | 1 | 1 selects word transfers (step 2), 0 selects byte transfers (step 1) |
| xfer_down | input | 1 | 1 steps the address down, 0 steps it up |
| wr_done | input | 1 | Write-phase handshake complete; the memory address steps at this edge |
| rd_addr | output | 24 | Read-phase bus address |
| wr_addr | output | 24 | Write-phase bus address |
| mem_is_dst | output | 1 | 1 when memory is the write side |

## Verification
The routing is tried with both memory-destination codes and with several other codes. This separates a decoder that tests only one of the two special codes from one that tests a range. Stepping is driven in all four size and direction combinations from one known address, which tells a sign error apart from a size error. Stepping is also driven across 0xFFFFFF and across 0x000000, which shows whether the carry leaks into the reserved lane. Writes that land in the same cycle as a step are made to a data lane, to the reserved lane and to the I/O register. These show which update wins and that a reserved-lane write cannot cancel a step.

// File: rtl/dmaau_pkg.sv
package dmaau_pkg;
  localparam int unsigned SRC_W = 3;
  // Activation codes for which memory is the write side
  localparam logic [SRC_W-1:0] SRC_SER_RX  = 3'd0;
  localparam logic [SRC_W-1:0] SRC_ADC_END = 3'd1;

  function automatic logic mem_dst_code(input logic [SRC_W-1:0] code);
    return (code == SRC_SER_RX) || (code == SRC_ADC_END);
  endfunction
endpackage

// File: rtl/dmaau_mar.sv
module dmaau_mar #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MEM_LANES = 4,
  parameter int unsigned BUS_AW    = 24,
  localparam int unsigned LANE_W    = $clog2(MEM_LANES),
  localparam int unsigned RSV_LANES = MEM_LANES - BUS_AW / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step_req,
  input  logic              step_word,
  input  logic              step_down,
  output logic [BUS_AW-1:0] addr_o
);
  logic [BUS_AW-1:0]    addr_q, addr_d, stepped, amt;
  logic [MEM_LANES-1:0] lane_hit;
  logic                 any_hit, do_step, load_en;

  for (genvar g = 0; g < MEM_LANES; g++) begin : g_lane
    if (g < RSV_LANES) begin : g_rsv
      assign lane_hit[g] = 1'b0;
    end else begin : g_data
      assign lane_hit[g] = wr_en && (wr_lane == LANE_W'(g));
    end
  end

  assign any_hit = |lane_hit;
  assign do_step = step_req && !any_hit;
  assign load_en = do_step || any_hit;

  always_comb begin
    amt     = step_word ? BUS_AW'(2) : BUS_AW'(1);
    stepped = step_down ? addr_q - amt : addr_q + amt;
  end

  always_comb begin
    addr_d = addr_q;
    if (do_step) addr_d = stepped;
    for (int l = RSV_LANES; l < MEM_LANES; l++) begin
      if (lane_hit[l]) addr_d[(MEM_LANES-1-l)*DATA_W +: DATA_W] = wr_data;
    end
  end

  // The register is deliberately left without reset; software loads it
  always_ff @(posedge clk) begin
    if (load_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !wr_en && !step_word && !step_down) |=> addr_o == $past(addr_o) + BUS_AW'(1));
  assert_step_dn_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !wr_en && step_word && step_down) |=> addr_o == $past(addr_o) - BUS_AW'(2));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_req && !wr_en) |=> $stable(addr_o));
  assert_cpu_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && wr_en && wr_lane == LANE_W'(MEM_LANES-1)) |=>
      (addr_o[DATA_W-1:0] == $past(wr_data)) &&
      (addr_o[BUS_AW-1:DATA_W] == $past(addr_o[BUS_AW-1:DATA_W])));
endmodule

// File: rtl/dmaau_ioar.sv
module dmaau_ioar #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] io_o
);
  logic [DATA_W-1:0] io_q, io_d;

  always_comb io_d = wr_data;

  // No reset by intent: software loads the offset before use
  always_ff @(posedge clk) begin
    if (wr_en) io_q <= io_d;
  end

  assign io_o = io_q;

  assert_io_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> io_o == $past(wr_data));
  assert_io_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(io_o));
endmodule

// File: rtl/dmaau_route.sv
module dmaau_route
  import dmaau_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  act_src,
  input  logic [BUS_AW-1:0] mem_addr,
  input  logic [DATA_W-1:0] io_low,
  output logic [BUS_AW-1:0] rd_addr,
  output logic [BUS_AW-1:0] wr_addr,
  output logic              mem_is_dst
);
  localparam int unsigned PAGE_W = BUS_AW - DATA_W;
  logic [BUS_AW-1:0] io_full;

  always_comb begin
    io_full    = {{PAGE_W{1'b1}}, io_low};
    mem_is_dst = mem_dst_code(act_src);
    if (mem_is_dst) begin
      rd_addr = io_full;
      wr_addr = mem_addr;
    end else begin
      rd_addr = mem_addr;
      wr_addr = io_full;
    end
  end

  assert_mem_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src == 3'd0 || act_src == 3'd1) |->
      (wr_addr == mem_addr) && (rd_addr[BUS_AW-1:DATA_W] == {PAGE_W{1'b1}}) && mem_is_dst);
  assert_mem_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src > 3'd1) |->
      (rd_addr == mem_addr) && (wr_addr[BUS_AW-1:DATA_W] == {PAGE_W{1'b1}}) && !mem_is_dst);
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dmaau_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MEM_LANES = 4,
  parameter int unsigned BUS_AW    = 24,
  localparam int unsigned LANE_W    = $clog2(MEM_LANES),
  localparam int unsigned RSV_LANES = MEM_LANES - BUS_AW / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_sel_io,
  input  logic [LANE_W-1:0] cpu_lane,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [SRC_W-1:0]  act_src,
  input  logic              xfer_word,
  input  logic              xfer_down,
  input  logic              wr_done,
  output logic [BUS_AW-1:0] rd_addr,
  output logic [BUS_AW-1:0] wr_addr,
  output logic              mem_is_dst
);
  logic [BUS_AW-1:0] mem_addr;
  logic [DATA_W-1:0] io_low;

  dmaau_mar #(.DATA_W(DATA_W), .MEM_LANES(MEM_LANES), .BUS_AW(BUS_AW)) i_mar (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_wr && !cpu_sel_io), .wr_lane(cpu_lane), .wr_data(cpu_wdata),
    .step_req(wr_done), .step_word(xfer_word), .step_down(xfer_down),
    .addr_o(mem_addr)
  );

  dmaau_ioar #(.DATA_W(DATA_W)) i_ioar (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_wr && cpu_sel_io), .wr_data(cpu_wdata), .io_o(io_low)
  );

  dmaau_route #(.DATA_W(DATA_W), .BUS_AW(BUS_AW)) i_route (
    .clk(clk), .rst_n(rst_n), .act_src(act_src),
    .mem_addr(mem_addr), .io_low(io_low),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .mem_is_dst(mem_is_dst)
  );

  always_comb begin
    cpu_rdata = '1;
    if (cpu_sel_io) begin
      cpu_rdata = io_low;
    end else begin
      for (int l = RSV_LANES; l < MEM_LANES; l++) begin
        if (cpu_lane == LANE_W'(l)) cpu_rdata = mem_addr[(MEM_LANES-1-l)*DATA_W +: DATA_W];
      end
    end
  end

  assert_rsv_reads_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sel_io && cpu_lane == '0) |-> cpu_rdata == '1);
endmodule

// File: tb/test_dma_addr_unit.sv
module test_dma_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr, cpu_sel_io, xfer_word, xfer_down, wr_done, mem_is_dst;
  logic [1:0]  cpu_lane;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [2:0]  act_src;
  logic [23:0] rd_addr, wr_addr;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_addr_unit i_dma_addr_unit (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel_io(cpu_sel_io),
    .cpu_lane(cpu_lane), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .act_src(act_src), .xfer_word(xfer_word), .xfer_down(xfer_down),
    .wr_done(wr_done), .rd_addr(rd_addr), .wr_addr(wr_addr), .mem_is_dst(mem_is_dst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One clocked CPU write, optionally together with a step
  task automatic cyc(input logic wr, input logic sel, input logic [1:0] lane,
                     input logic [7:0] d, input logic done, input logic word, input logic down);
    @(negedge clk);
    cpu_wr = wr; cpu_sel_io = sel; cpu_lane = lane; cpu_wdata = d;
    wr_done = done; xfer_word = word; xfer_down = down;
    @(negedge clk);
    cpu_wr = 1'b0; wr_done = 1'b0;
  endtask

  task automatic load_mem(input logic [23:0] a);
    cyc(1'b1, 1'b0, 2'd1, a[23:16], 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 2'd2, a[15:8],  1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 2'd3, a[7:0],   1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_lane(input logic sel, input logic [1:0] lane, output logic [7:0] v);
    cpu_sel_io = sel; cpu_lane = lane; #1; v = cpu_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_lane(1'b0, 2'd0, v);
    chk("R1 lane0 after reset", 32'(v), 32'hFF);
  endtask

  task automatic t_lanes();
    logic [7:0] v;
    load_mem(24'h123456);
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    rd_lane(1'b0, 2'd0, v); chk("R1 lane0 write ignored", 32'(v), 32'hFF);
    rd_lane(1'b0, 2'd1, v); chk("R2 lane1", 32'(v), 32'h12);
    rd_lane(1'b0, 2'd2, v); chk("R2 lane2", 32'(v), 32'h34);
    rd_lane(1'b0, 2'd3, v); chk("R2 lane3", 32'(v), 32'h56);
    cyc(1'b1, 1'b1, 2'd2, 8'h9A, 1'b0, 1'b0, 1'b0);
    rd_lane(1'b1, 2'd0, v); chk("R2 io readback", 32'(v), 32'h9A);
  endtask

  task automatic t_route();
    act_src = 3'd0; #1;
    chk("R3 rd code0", 32'(rd_addr), 32'hFFFF9A);
    chk("R3 wr code0", 32'(wr_addr), 32'h123456);
    chk("R3 dst code0", 32'(mem_is_dst), 32'd1);
    act_src = 3'd1; #1;
    chk("R3 rd code1", 32'(rd_addr), 32'hFFFF9A);
    chk("R3 wr code1", 32'(wr_addr), 32'h123456);
    for (int c = 2; c < 8; c++) begin
      act_src = 3'(c); #1;
      chk("R4 rd other", 32'(rd_addr), 32'h123456);
      chk("R4 wr other", 32'(wr_addr), 32'hFFFF9A);
      chk("R4 dst other", 32'(mem_is_dst), 32'd0);
    end
    act_src = 3'd2;
  endtask

  task automatic t_step();
    logic [7:0] v;
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 byte up", 32'(rd_addr), 32'h123457);
    repeat (3) @(negedge clk);
    chk("R9 hold", 32'(rd_addr), 32'h123457);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R6 word up", 32'(rd_addr), 32'h123459);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R6 word down", 32'(rd_addr), 32'h123457);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1);
    chk("R6 byte down", 32'(rd_addr), 32'h123456);
    rd_lane(1'b1, 2'd0, v); chk("R10 io untouched by steps", 32'(v), 32'h9A);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    load_mem(24'hFFFFFF);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R7 wrap up", 32'(rd_addr), 32'h000000);
    rd_lane(1'b0, 2'd0, v); chk("R7 lane0 after wrap", 32'(v), 32'hFF);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R7 wrap down word", 32'(rd_addr), 32'hFFFFFE);
    load_mem(24'h000001);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R7 wrap down to top", 32'(rd_addr), 32'hFFFFFF);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    load_mem(24'h123456);
    cyc(1'b1, 1'b0, 2'd3, 8'hAA, 1'b1, 1'b0, 1'b0);
    chk("R8 cpu write beats step", 32'(rd_addr), 32'h1234AA);
    cyc(1'b1, 1'b0, 2'd1, 8'h77, 1'b1, 1'b1, 1'b0);
    chk("R8 upper lane write beats step", 32'(rd_addr), 32'h7734AA);
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R8 reserved lane write does not block", 32'(rd_addr), 32'h7734AB);
    cyc(1'b1, 1'b1, 2'd0, 8'h3C, 1'b1, 1'b0, 1'b0);
    chk("R10 mem steps with io write", 32'(rd_addr), 32'h7734AC);
    rd_lane(1'b1, 2'd0, v); chk("R10 io written in step cycle", 32'(v), 32'h3C);
    chk("R4 io page after rewrite", 32'(wr_addr), 32'hFFFF3C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_sel_io = 1'b0; cpu_lane = 2'd0; cpu_wdata = 8'h00;
    act_src = 3'd2; xfer_word = 1'b0; xfer_down = 1'b0; wr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_route();
    t_step();
    t_wrap();
    t_priority();
    summary();
    $finish;
  end
endmodule